// File: doc/BRIEF.md
# Reset Sequencer with Vector Fetch

This block decides when a small 8-bit processor core may start executing, and where it starts. Two sources can request a reset: an active-low board pin, which counts only after it has stayed low for a minimum number of clock cycles, and a single-cycle pulse from the watchdog. After every request has gone away, the sequencer waits out an oscillator settling period. That period is built from a prescaled tick count. A short fixed process phase follows it.

Next the sequencer reads the two-byte start vector over a byte-wide read port: first the low byte at FFFEh, then the high byte at FFFFh. It latches the result as the program counter and only then lets the core run. While the core is held, the sequencer tells it to load its power-up values: data page zero, status flag clear, peripheral clock gated off and watchdog disabled. Memory is only ever read, so RAM keeps its contents through a reset.

Top module: `boot_reset_ctrl`

## Requirements
- R1: After the block's own reset `rst` falls, `core_run` stays low for STAB_DIV*STAB_TICKS+PROC_CYC+2 clock edges and is high after edge STAB_DIV*STAB_TICKS+PROC_CYC+3 (called N below).
- R2: When `ext_rst_n` is sampled low on MIN_LOW or more consecutive edges, the core is stopped. Once the pin is high again, `core_run` rises after the (N+4)-th edge that follows the last low sample.
- R3: A low pulse on `ext_rst_n` lasting fewer than MIN_LOW edges has no effect. `core_run` stays high, `pc_out` is unchanged and no memory read is issued.
- R4: A one-cycle `wdt_rst` pulse drops `core_run` at the edge that samples it. `core_run` rises again after N+1 edges counted from that edge.
- R5: Each boot performs exactly two reads on consecutive cycles. `mem_rd` is high with `mem_addr`=FFFEh and then with `mem_addr`=FFFFh. `mem_rdata` is taken as valid one cycle after its read.
- R6: While `core_run` is high, `pc_out` equals {byte from FFFFh, byte from FFFEh} and holds steady.
- R7: A new reset request arriving at any point in the settling, process or fetch phases restarts the whole sequence. Release then follows R4 timing from the new request.
- R8: While the core is held, `init_load` is 1, `pclk_en` is 0, `dpage_init` is 00h, `gflag_init` is 0 and `wdt_en_init` is 0. While it runs, `init_load` is 0 and `pclk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset of the sequencer |
| ext_rst_n | input | 1 | Asynchronous active-low board reset pin |
| wdt_rst | input | 1 | One-cycle watchdog reset request |
| mem_rd | output | 1 | Read strobe to program memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| core_run | output | 1 | Core may execute |
| pc_out | output | 16 | Start address, valid while core_run is high |
| init_load | output | 1 | Core loads its power-up register values |
| dpage_init | output | 8 | Power-up data page value |
| gflag_init | output | 1 | Power-up status flag value |
| pclk_en | output | 1 | Peripheral clock enable |
| wdt_en_init | output | 1 | Power-up watchdog enable value |

## Verification
The hardest case is a second request that lands in the middle of the sequence, for example during the cycle that issues the high-byte read or the cycle just before release. It only happens when a request coincides with one internal phase boundary. The bench reaches every such point by firing a watchdog pulse, then a second one at each offset from 1 to N edges later. After each second pulse it checks that release again follows the full N+1 count and that the new vector is used. A sweep of pin pulse widths from 1 to MIN_LOW+2 covers the acceptance threshold on both sides.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = 16'hFFFE;
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = 16'hFFFF;

    localparam logic [BYTE_W-1:0] INIT_DPAGE  = 8'h00;
    localparam logic              INIT_GFLAG  = 1'b0;
    localparam logic              INIT_WDT_EN = 1'b0;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_STAB,
        ST_PROC,
        ST_RD_LO,
        ST_RD_HI,
        ST_CAP_HI,
        ST_RUN
    } boot_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } vec_pair_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic qual
);
    localparam int CW = boot_rst_pkg::cnt_width(MIN_LOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

    logic          sync_a;
    logic          sync_b;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pin_n;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync_b) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qual = (low_cnt == LIMIT);

endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
    parameter int DIV   = 1024,
    parameter int TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic done
);
    localparam int PW = boot_rst_pkg::cnt_width(DIV);
    localparam int TW = boot_rst_pkg::cnt_width(TICKS);
    localparam logic [PW-1:0] PRE_LAST  = PW'(DIV - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = run_en && (pre_cnt == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick) begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assign done = tick && (tick_cnt == TICK_LAST);

endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int LEN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic done
);
    localparam int CW = boot_rst_pkg::cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run_en && (cnt == LAST);

endmodule

// File: rtl/vec_capture.sv
module vec_capture
    import boot_rst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [BYTE_W-1:0] rdata,
    output logic [PC_W-1:0]   pc
);
    vec_pair_t vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            if (cap_lo) vec_q.lo <= rdata;
            if (cap_hi) vec_q.hi <= rdata;
        end
    end

    assign pc = vec_q;

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
    import boot_rst_pkg::*;
#(
    parameter int MIN_LOW    = 8,
    parameter int STAB_DIV   = 1024,
    parameter int STAB_TICKS = 256,
    parameter int PROC_CYC   = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_rst_n,
    input  logic        wdt_rst,
    output logic        mem_rd,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        core_run,
    output logic [15:0] pc_out,
    output logic        init_load,
    output logic [7:0]  dpage_init,
    output logic        gflag_init,
    output logic        pclk_en,
    output logic        wdt_en_init
);
    boot_state_e state;
    logic        pin_qual;
    logic        req;
    logic        stab_done;
    logic        proc_done;

    rst_pin_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_rst_n),
        .qual  (pin_qual)
    );

    stab_timer #(.DIV(STAB_DIV), .TICKS(STAB_TICKS)) u_stab (
        .clk    (clk),
        .rst    (rst),
        .run_en (state == ST_STAB),
        .done   (stab_done)
    );

    step_timer #(.LEN(PROC_CYC)) u_proc (
        .clk    (clk),
        .rst    (rst),
        .run_en (state == ST_PROC),
        .done   (proc_done)
    );

    vec_capture u_vec (
        .clk    (clk),
        .rst    (rst),
        .cap_lo (state == ST_RD_HI),
        .cap_hi (state == ST_CAP_HI),
        .rdata  (mem_rdata),
        .pc     (pc_out)
    );

    assign req = pin_qual || wdt_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_STAB;
        end else if (req) begin
            state <= ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:   state <= ST_STAB;
                ST_STAB:   if (stab_done) state <= ST_PROC;
                ST_PROC:   if (proc_done) state <= ST_RD_LO;
                ST_RD_LO:  state <= ST_RD_HI;
                ST_RD_HI:  state <= ST_CAP_HI;
                ST_CAP_HI: state <= ST_RUN;
                ST_RUN:    state <= ST_RUN;
                default:   state <= ST_HOLD;
            endcase
        end
    end

    always_comb begin
        mem_rd   = (state == ST_RD_LO) || (state == ST_RD_HI);
        mem_addr = (state == ST_RD_HI) ? VEC_HI_ADDR : VEC_LO_ADDR;
    end

    assign core_run    = (state == ST_RUN);
    assign init_load   = !core_run;
    assign pclk_en     = core_run;
    assign dpage_init  = INIT_DPAGE;
    assign gflag_init  = INIT_GFLAG;
    assign wdt_en_init = INIT_WDT_EN;

endmodule

// File: rtl/boot_reset_ctrl_chk.sv
module boot_reset_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wdt_rst,
    input logic        mem_rd,
    input logic [15:0] mem_addr,
    input logic        core_run,
    input logic [15:0] pc_out
);
    // R5: release only two cycles after the high-byte read
    p_fetch_then_run_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run) |-> ($past(mem_rd, 2) && $past(mem_addr, 2) == 16'hFFFF));

    // R5: high byte read directly follows the low byte read
    p_lo_before_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_addr == 16'hFFFF) |-> $past(mem_rd && mem_addr == 16'hFFFE));

    // R5: reads touch the vector pair only
    p_vec_addr_only_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == 16'hFFFE || mem_addr == 16'hFFFF));

    // R4: watchdog request stops the core on the next cycle
    p_wdt_stops_r4: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !core_run);

    // R6: start address steady while running
    p_pc_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (core_run && $past(core_run)) |-> $stable(pc_out));

    // R8: no fetch traffic while the core runs
    p_quiet_run_r8: assert property (@(posedge clk) disable iff (rst)
        core_run |-> !mem_rd);

endmodule

bind boot_reset_ctrl boot_reset_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wdt_rst  (wdt_rst),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .core_run (core_run),
    .pc_out   (pc_out)
);

// File: tb/tb_boot_reset_ctrl.sv
module tb_boot_reset_ctrl;
    localparam int MIN_LOW = 8;
    localparam int DIV     = 4;
    localparam int TICKS   = 3;
    localparam int PROC    = 7;
    localparam int N       = DIV * TICKS + PROC + 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_rst_n;
    logic        wdt_rst;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        core_run;
    logic [15:0] pc_out;
    logic        init_load;
    logic [7:0]  dpage_init;
    logic        gflag_init;
    logic        pclk_en;
    logic        wdt_en_init;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int ord_err = 0;
    logic prev_lo = 1'b0;
    logic [7:0] vec_lo;
    logic [7:0] vec_hi;

    always #5 clk = ~clk;

    boot_reset_ctrl #(
        .MIN_LOW(MIN_LOW), .STAB_DIV(DIV), .STAB_TICKS(TICKS), .PROC_CYC(PROC)
    ) dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_rst(wdt_rst),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .core_run(core_run), .pc_out(pc_out), .init_load(init_load),
        .dpage_init(dpage_init), .gflag_init(gflag_init), .pclk_en(pclk_en),
        .wdt_en_init(wdt_en_init)
    );

    // program memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) begin
            rd_cnt++;
            if (mem_addr == 16'hFFFF && !prev_lo) ord_err++;
            if (mem_addr != 16'hFFFE && mem_addr != 16'hFFFF) ord_err++;
            mem_rdata <= (mem_addr == 16'hFFFE) ? vec_lo :
                         (mem_addr == 16'hFFFF) ? vec_hi : 8'h00;
        end
        prev_lo = mem_rd && (mem_addr == 16'hFFFE);
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expect core_run low after edge n-1 and high with the vector after edge n
    task automatic boot_check(input int n, input string tag);
        for (int i = 1; i <= n; i++) begin
            tick();
            if (i == n - 1)
                chk(core_run == 1'b0, {tag, " early release"}, 32'(core_run), 0);
            if (i == n) begin
                chk(core_run == 1'b1, {tag, " release edge"}, 32'(core_run), 1);
                chk(pc_out == {vec_hi, vec_lo}, {tag, " R6 pc"}, 32'(pc_out),
                    32'({vec_hi, vec_lo}));
            end
        end
    endtask

    task automatic wdt_pulse();
        wdt_rst = 1'b1;
        tick();
        wdt_rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        ext_rst_n = 1'b1;
        wdt_rst = 1'b0;
        vec_lo = 8'h34;
        vec_hi = 8'h12;
        tick(); tick(); tick();

        // R8: held state values
        chk(core_run == 1'b0, "R8 run in reset", 32'(core_run), 0);
        chk(init_load == 1'b1, "R8 init_load", 32'(init_load), 1);
        chk(pclk_en == 1'b0, "R8 pclk off", 32'(pclk_en), 0);
        chk(dpage_init == 8'h00, "R8 dpage", 32'(dpage_init), 0);
        chk(gflag_init == 1'b0, "R8 gflag", 32'(gflag_init), 0);
        chk(wdt_en_init == 1'b0, "R8 wdt off", 32'(wdt_en_init), 0);

        // R1: power-up timing, R5: exactly two reads
        rd_cnt = 0;
        rst = 1'b0;
        boot_check(N, "R1 power-up");
        chk(rd_cnt == 2, "R5 read count", 32'(rd_cnt), 2);
        chk(init_load == 1'b0, "R8 init_load run", 32'(init_load), 0);
        chk(pclk_en == 1'b1, "R8 pclk run", 32'(pclk_en), 1);

        // R2 / R3: sweep pin low widths across the threshold
        for (int len = 1; len <= MIN_LOW + 2; len++) begin
            logic [15:0] pc_before;
            int drops;
            pc_before = pc_out;
            vec_lo = 8'(len * 17 + 1);
            vec_hi = 8'(len * 5 + 64);
            rd_cnt = 0;
            ext_rst_n = 1'b0;
            for (int i = 0; i < len; i++) tick();
            ext_rst_n = 1'b1;
            if (len >= MIN_LOW) begin
                boot_check(N + 4, "R2 pin accepted");
                chk(rd_cnt == 2, "R2 reads after pin", 32'(rd_cnt), 2);
            end else begin
                drops = 0;
                for (int i = 0; i < N + 8; i++) begin
                    tick();
                    if (!core_run) drops++;
                end
                chk(drops == 0, "R3 short pulse ignored", 32'(drops), 0);
                chk(pc_out == pc_before, "R3 pc kept", 32'(pc_out), 32'(pc_before));
                chk(rd_cnt == 0, "R3 no reads", 32'(rd_cnt), 0);
            end
        end

        // R2: long hold keeps core stopped
        vec_lo = 8'hA5;
        vec_hi = 8'h5A;
        ext_rst_n = 1'b0;
        for (int i = 0; i < 3 * N; i++) tick();
        chk(core_run == 1'b0, "R2 held low", 32'(core_run), 0);
        chk(init_load == 1'b1, "R8 init while held", 32'(init_load), 1);
        ext_rst_n = 1'b1;
        boot_check(N + 4, "R2 long hold");

        // R4: watchdog pulse
        vec_lo = 8'h0F;
        vec_hi = 8'hF0;
        wdt_pulse();
        chk(core_run == 1'b0, "R4 stop edge", 32'(core_run), 0);
        boot_check(N + 1, "R4 watchdog");

        // R7: second request at every offset of the sequence
        for (int k = 1; k <= N; k++) begin
            vec_lo = 8'(k * 3 + 7);
            vec_hi = 8'(255 - k);
            wdt_pulse();
            for (int i = 1; i < k; i++) tick();
            wdt_pulse();
            boot_check(N + 1, "R7 restart");
        end

        chk(ord_err == 0, "R5 read order", 32'(ord_err), 0);

        summary();
        $finish;
    end

endmodule